// File: doc/BRIEF.md
# Configuration Window Address Translator

This block turns a configuration-space request, made of a bus number, a device/function number and a register offset, into a 64-bit address inside a memory-mapped configuration window. Software programs the window through a small word-indexed register port: an enable bit, a bus-range size field and a 64-bit window base split into two 32-bit words. A read-only capability word reports that the translator is present.

Before producing an address, the block decides whether the target may be touched at all. On the root bus, whose number is itself programmable, only device/function zero exists. Any other bus is reachable only while the link-up input is high. A disabled window rejects everything. A rejected request yields a reject flag and an all-zero address, so no access is started downstream. The highest usable bus number is presented continuously from the size field.

Top module: `cfg_window_xlate`

## Requirements
- R1: After reset the window is disabled, the size field is 12 (so `last_bus` is 12), the base and root bus number are 0, and `rsp_valid`, `rsp_ok` and `rsp_reject` are 0.
- R2: A register read (`reg_re` high with `reg_idx`) returns its data on `reg_rdata` one cycle later; index 0 is the capability word and reads 0x00000001 (bit 0 = translator present), and unused indices 5 to 7 read 0.
- R3: Index 1 is control: bit 0 is the window enable and bits 20:16 the size value; all other bits read back as 0, and `last_bus` equals bits 20:16 zero-extended from the cycle after the write.
- R4: One cycle after an accepted request, `rsp_valid` and `rsp_ok` are 1 and `rsp_addr` equals the window base plus ((bus << 20) | (devfn << 12) | offset).
- R5: While the enable bit is 0, every request is answered with `rsp_reject` = 1.
- R6: On the root bus a request with devfn other than 0 is rejected; devfn 0 on the root bus is accepted whatever `link_up` is.
- R7: A request to any bus other than the root bus is accepted only when `link_up` is 1 in the request cycle.
- R8: A rejected response has `rsp_ok` = 0 and `rsp_addr` = 0.
- R9: A cycle without `req_valid` gives `rsp_valid`, `rsp_ok` and `rsp_reject` all 0 in the next cycle.
- R10: Index 4 holds the root bus number in bits 7:0, is readable, and the rules of R6 and R7 use its current value.
- R11: Index 2 holds base bits 31:0 and index 3 base bits 63:32; the address sum carries from the low half into the high half.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| link_up | input | 1 | Link status; gates non-root buses |
| req_valid | input | 1 | Request strobe |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_offset | input | 12 | Register offset inside the function |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Request accepted, address valid |
| rsp_reject | output | 1 | Request refused |
| rsp_addr | output | 64 | Window address, zero when refused |
| last_bus | output | 8 | Highest usable bus number from the size field |

## Verification
The bench aims at the root-bus boundary: devfn 0 versus non-zero on the root bus with the link down, where a design that applied the link rule to the root bus would refuse the only legal target, and one that ignored devfn would reach phantom functions. It moves the root bus number away from 0 so that a design hardwiring bus 0 as root is caught on both sides, and it loads a base whose low half overflows so that a design adding only 32 bits loses the carry. It also checks that a disabled window refuses requests and that refused responses carry a zeroed address, since a design leaking the computed address would start a stray access.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  typedef enum logic [2:0] {
    IDX_CAP     = 3'd0,
    IDX_CTRL    = 3'd1,
    IDX_BASE_LO = 3'd2,
    IDX_BASE_HI = 3'd3,
    IDX_ROOT    = 3'd4
  } reg_idx_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int SIZE_LSB     = 16;
  localparam int SIZE_W       = 5;
  localparam int SIZE_RESET   = 12;
endpackage

// File: rtl/cfg_xlate_regs.sv
module cfg_xlate_regs
  import cfg_xlate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BUS_W  = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              win_en,
  output logic [SIZE_W-1:0] win_size,
  output logic [ADDR_W-1:0] win_base,
  output logic [BUS_W-1:0]  root_bus
);
  logic [DATA_W-1:0] base_lo, base_hi;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en   <= 1'b0;
      win_size <= SIZE_W'(SIZE_RESET);
      base_lo  <= '0;
      base_hi  <= '0;
      root_bus <= '0;
    end else if (reg_we) begin
      case (reg_idx_e'(reg_idx))
        IDX_CTRL: begin
          win_en   <= reg_wdata[CTRL_EN_BIT];
          win_size <= reg_wdata[SIZE_LSB +: SIZE_W];
        end
        IDX_BASE_LO: base_lo  <= reg_wdata;
        IDX_BASE_HI: base_hi  <= reg_wdata;
        IDX_ROOT:    root_bus <= reg_wdata[BUS_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_idx_e'(reg_idx))
      IDX_CAP: rd_mux[0] = 1'b1;
      IDX_CTRL: begin
        rd_mux[CTRL_EN_BIT]          = win_en;
        rd_mux[SIZE_LSB +: SIZE_W]   = win_size;
      end
      IDX_BASE_LO: rd_mux = base_lo;
      IDX_BASE_HI: rd_mux = base_hi;
      IDX_ROOT:    rd_mux[BUS_W-1:0] = root_bus;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  assign win_base = {base_hi, base_lo};

  p_reset_size_r1: assert property (@(posedge clk) rst |=> (win_size == SIZE_W'(SIZE_RESET) && !win_en));
endmodule

// File: rtl/cfg_xlate_check.sv
module cfg_xlate_check #(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8
) (
  input  logic               win_en,
  input  logic               link_up,
  input  logic [BUS_W-1:0]   root_bus,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  output logic               permit
);
  logic on_root;

  always_comb begin
    on_root = (req_bus == root_bus);
    if (!win_en)      permit = 1'b0;
    else if (on_root) permit = (req_devfn == '0);
    else              permit = link_up;
  end
endmodule

// File: rtl/cfg_xlate_addr.sv
module cfg_xlate_addr #(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int OFS_W   = 12,
  parameter int ADDR_W  = 64,
  localparam int REL_W  = BUS_W + DEVFN_W + OFS_W,
  localparam int PAD_W  = ADDR_W - REL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               permit,
  input  logic [ADDR_W-1:0]  win_base,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [OFS_W-1:0]   req_offset,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_reject,
  output logic [ADDR_W-1:0]  rsp_addr
);
  logic [ADDR_W-1:0] rel_addr;
  logic [ADDR_W-1:0] sum_addr;

  assign rel_addr = {{PAD_W{1'b0}}, req_bus, req_devfn, req_offset};
  assign sum_addr = win_base + rel_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_reject <= 1'b0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_ok     <= req_valid && permit;
      rsp_reject <= req_valid && !permit;
      rsp_addr   <= (req_valid && permit) ? sum_addr : '0;
    end
  end

  p_reject_zero_r8: assert property (@(posedge clk) disable iff (rst) rsp_reject |-> (rsp_addr == '0 && !rsp_ok));
  p_idle_r9: assert property (@(posedge clk) disable iff (rst) !req_valid |=> (!rsp_valid && !rsp_ok && !rsp_reject));
  p_flag_pair_r4: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> (rsp_ok != rsp_reject));
endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int OFS_W   = 12,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [2:0]         reg_idx,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               link_up,
  input  logic               req_valid,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [OFS_W-1:0]   req_offset,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_reject,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic [BUS_W-1:0]   last_bus
);
  logic              win_en;
  logic [SIZE_W-1:0] win_size;
  logic [ADDR_W-1:0] win_base;
  logic [BUS_W-1:0]  root_bus;
  logic              permit;

  cfg_xlate_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_en(win_en),
    .win_size(win_size), .win_base(win_base), .root_bus(root_bus)
  );

  cfg_xlate_check #(.BUS_W(BUS_W), .DEVFN_W(DEVFN_W)) u_check (
    .win_en(win_en), .link_up(link_up), .root_bus(root_bus),
    .req_bus(req_bus), .req_devfn(req_devfn), .permit(permit)
  );

  cfg_xlate_addr #(.BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .req_valid(req_valid), .permit(permit),
    .win_base(win_base), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_reject(rsp_reject), .rsp_addr(rsp_addr)
  );

  assign last_bus = {{(BUS_W-SIZE_W){1'b0}}, win_size};

  p_disabled_r5: assert property (@(posedge clk) disable iff (rst) (req_valid && !win_en) |=> rsp_reject);
  p_root_devfn_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bus == root_bus && req_devfn != '0) |=> rsp_reject);
  p_link_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bus != root_bus && !link_up) |=> rsp_reject);
endmodule

// File: tb/cfg_window_xlate_tb.sv
module cfg_window_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        link_up = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_bus = '0, req_devfn = '0;
  logic [11:0] req_offset = '0;
  logic        rsp_valid, rsp_ok, rsp_reject;
  logic [63:0] rsp_addr;
  logic [7:0]  last_bus;

  int checks = 0, fails = 0;
  bit done = 0;

  logic        m_en = 1'b0;
  logic [4:0]  m_size = 5'd12;
  logic [63:0] m_base = '0;
  logic [7:0]  m_root = '0;

  always #10 clk = ~clk;

  cfg_window_xlate u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
    .req_valid(req_valid), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_reject(rsp_reject), .rsp_addr(rsp_addr), .last_bus(last_bus)
  );

  function automatic bit exp_ok(input [7:0] b, input [7:0] d, input l);
    if (!m_en) return 1'b0;
    if (b == m_root) return d == 8'd0;
    return l;
  endfunction

  function automatic [63:0] exp_addr(input [7:0] b, input [7:0] d, input [11:0] o);
    return m_base + {36'd0, b, d, o};
  endfunction

  task automatic check(input bit cond, input string tag, input [63:0] act, input [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input [2:0] idx, input [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (idx)
      3'd1: begin m_en = d[0]; m_size = d[20:16]; end
      3'd2: m_base[31:0] = d;
      3'd3: m_base[63:32] = d;
      3'd4: m_root = d[7:0];
      default: ;
    endcase
  endtask

  task automatic rd_check(input [2:0] idx, input [31:0] exp, input string tag);
    @(negedge clk);
    reg_re = 1'b1; reg_idx = idx;
    @(negedge clk);
    reg_re = 1'b0;
    check(reg_rdata == exp, tag, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic do_req(input [7:0] b, input [7:0] d, input [11:0] o, input l, input string tag);
    bit ok;
    logic [63:0] ea;
    @(negedge clk);
    req_valid = 1'b1; req_bus = b; req_devfn = d; req_offset = o; link_up = l;
    ok = exp_ok(b, d, l);
    ea = ok ? exp_addr(b, d, o) : 64'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_ok == ok && rsp_reject == !ok && rsp_addr == ea, tag,
          rsp_addr ^ {61'd0, rsp_valid, rsp_ok, rsp_reject} ^ {61'd0, rsp_valid, rsp_ok, rsp_reject},
          ea);
    if (!(rsp_ok == ok && rsp_reject == !ok))
      $display("  flags ok=%0b rej=%0b expected ok=%0b", rsp_ok, rsp_reject, ok);
  endtask

  function automatic string pick_tag(input [7:0] b, input [7:0] d, input l);
    if (!m_en) return "R5";
    if (b == m_root && d != 0) return "R6";
    if (b != m_root && !l) return "R7";
    return "R4";
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!rsp_valid && !rsp_ok && !rsp_reject, "R1", {61'd0, rsp_valid, rsp_ok, rsp_reject}, 64'd0);
    check(last_bus == 8'd12, "R1", {56'd0, last_bus}, 64'd12);
    rd_check(3'd1, 32'h000C_0000, "R1");
    rd_check(3'd2, 32'h0, "R1");
    rd_check(3'd4, 32'h0, "R1");
    // R2 capability and unused words
    rd_check(3'd0, 32'h1, "R2");
    rd_check(3'd6, 32'h0, "R2");
    // R5 disabled window
    do_req(8'd0, 8'd0, 12'h010, 1'b1, "R5");
    do_req(8'd3, 8'd8, 12'h100, 1'b1, "R5");
    // R3 control field
    wr(3'd1, 32'hFFFF_FFFF);
    rd_check(3'd1, 32'h001F_0001, "R3");
    check(last_bus == 8'd31, "R3", {56'd0, last_bus}, 64'd31);
    wr(3'd1, 32'h0007_0001);
    check(last_bus == 8'd7, "R3", {56'd0, last_bus}, 64'd7);
    // R9 idle
    @(negedge clk);
    check(!rsp_valid && !rsp_ok && !rsp_reject, "R9", {61'd0, rsp_valid, rsp_ok, rsp_reject}, 64'd0);
    // R11 base words, with carry
    wr(3'd2, 32'hFFFF_F000);
    wr(3'd3, 32'h0000_0001);
    rd_check(3'd2, 32'hFFFF_F000, "R11");
    rd_check(3'd3, 32'h0000_0001, "R11");
    do_req(8'd0, 8'd0, 12'hFFC, 1'b0, "R6");
    do_req(8'd1, 8'd0, 12'h004, 1'b1, "R11");
    // R6 root rules with link down
    do_req(8'd0, 8'd1, 12'h000, 1'b0, "R6");
    do_req(8'd0, 8'd1, 12'h000, 1'b1, "R6");
    // R7 link gate
    do_req(8'd2, 8'd0, 12'h040, 1'b0, "R7");
    do_req(8'd2, 8'd0, 12'h040, 1'b1, "R7");
    do_req(8'd255, 8'd255, 12'hFFF, 1'b1, "R4");
    // R8 refused response zero address
    do_req(8'd9, 8'd5, 12'h123, 1'b0, "R8");
    // R10 root bus moved
    wr(3'd4, 32'h0000_0005);
    rd_check(3'd4, 32'h5, "R10");
    do_req(8'd5, 8'd0, 12'h008, 1'b0, "R10");
    do_req(8'd5, 8'd2, 12'h008, 1'b1, "R10");
    do_req(8'd0, 8'd2, 12'h008, 1'b1, "R10");
    do_req(8'd0, 8'd0, 12'h008, 1'b0, "R10");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] b, d;
      logic [11:0] o;
      logic l;
      if (i % 100 == 0) begin
        wr(3'd2, $urandom);
        wr(3'd3, $urandom);
        wr(3'd4, {24'd0, 8'($urandom_range(0, 3))});
        wr(3'd1, {11'd0, 5'($urandom), 15'd0, 1'(($urandom % 5) != 0)});
      end
      b = ($urandom % 3 == 0) ? m_root : 8'($urandom_range(0, 7));
      d = ($urandom % 2 == 0) ? 8'd0 : 8'($urandom);
      o = 12'($urandom);
      l = 1'($urandom);
      do_req(b, d, o, l, pick_tag(b, d, l));
      if (i % 37 == 0) begin
        @(negedge clk);
        check(!rsp_valid && !rsp_ok && !rsp_reject, "R9", {61'd0, rsp_valid, rsp_ok, rsp_reject}, 64'd0);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule